// File: doc/BRIEF.md
# Crosstalk Offset Binary-Search Calibrator

This block finds the signed offset that cancels unwanted infrared crosstalk in a proximity channel. The offset is a sign bit plus an 8-bit magnitude, so it spans -255 to +255. A positive offset is subtracted from the accumulated signal, which means a larger positive offset gives a smaller result. A calibration first measures with a zero offset to choose the sign. It then runs a successive-approximation search over the magnitude, most significant bit first. The search settles on the offset that leaves the measured result just above a programmable target, without letting the result fall to zero.

Each trial offset goes to an external measurement engine over a request/done handshake, and the engine returns an 8-bit result. When the last bit has been decided, the block loads the final value into its offset registers and sets a sticky done flag and a sticky interrupt flag. In electrical-only mode the photodiode-connect output stays inactive for the whole run. A calibration of this kind starts by itself when reset is released. Outside calibration, an optional auto-adjust function lowers the stored magnitude by one each time a normal-operation result reads zero.

Top module: `xtcal_top`

## Requirements
- R1: The first measurement of a run uses offset +0. If its result is greater than the target, the sign becomes positive (`offset_sign`=0); otherwise it becomes negative (`offset_sign`=1).
- R2: For a positive sign, the final magnitude is the largest value for which the measured result stays strictly greater than the target.
- R3: For a negative sign, the final magnitude is the smallest value for which the result becomes strictly greater than the target. This is the largest magnitude whose result is still at or below the target, plus one, saturating at 255.
- R4: The 3-bit `target_code` n selects a target of 2^n - 1, one of 0, 1, 3, 7, 15, 31, 63 or 127. The code is captured when a run starts.
- R5: Every run makes exactly 9 measurements. `meas_req` stays high until the cycle in which `meas_done` is sampled high, and falls on the next clock.
- R6: While a run started with `elec_only`=1 is active, `pd_connect` is 0. During any other run it is 1.
- R7: At the end of a run, `offset_sign`/`offset_mag` take the final value and `cal_done` and `cal_irq` rise in the same clock, with `cal_busy` low. The offset registers do not change while a run is active. An accepted start clears `cal_done`. `irq_clr` clears `cal_irq` and leaves `cal_done` alone.
- R8: When the block is idle, `auto_adj_en`=1, `run_valid`=1 and `run_result`=0, a nonzero `offset_mag` drops by one on the next clock. It stays unchanged for any nonzero result, when auto-adjust is off, or when the magnitude is already 0. The sign never changes.
- R9: Reset clears the offset registers, `cal_done` and `cal_irq`. After reset is released, an electrical-only run starts without any start pulse, using the `target_code` present during reset.
- R10: A `cal_start` pulse that arrives during a run is ignored. The run keeps its captured target and mode and still makes 9 measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Start pulse, accepted only when idle |
| elec_only | input | 1 | Run keeps the photodiode disconnected |
| target_code | input | 3 | Target exponent n, target = 2^n - 1 |
| irq_clr | input | 1 | Clears the calibration interrupt flag |
| auto_adj_en | input | 1 | Enables runtime auto-decrement |
| meas_req | output | 1 | Measurement request, held until done |
| trial_mag | output | 8 | Trial offset magnitude under test |
| trial_sign | output | 1 | Trial offset sign, 1 = negative |
| pd_connect | output | 1 | Photodiode connect enable |
| meas_done | input | 1 | Measurement complete, one-cycle pulse |
| meas_result | input | 8 | Measurement result, valid with meas_done |
| run_valid | input | 1 | Normal-operation result valid |
| run_result | input | 8 | Normal-operation result |
| offset_mag | output | 8 | Stored offset magnitude |
| offset_sign | output | 1 | Stored offset sign, 1 = negative |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Sticky calibration-complete flag |
| cal_irq | output | 1 | Sticky calibration interrupt flag |

## Verification
The bench drives runs at the extremes of the search. One starts at a raw level of 255 with a target of 0, where the answer is +254. One starts at 0 with a target of 0 and needs -1. One starts exactly at the target, where the sign test must choose negative. One starts one count above the target, where every magnitude bit must be discarded. A design that compared with the wrong polarity or off by one would settle one step away, and a design that missed the +1 on the negative side would leave the result at or below the target. A second start pulse in the middle of a run, carrying a different target and mode, exposes a design that restarts or re-captures settings; that shows up as a wrong offset or a tenth measurement. The runtime decrement is tested at a nonzero magnitude, at zero, with a nonzero result and with auto-adjust disabled, so it catches wrap-around and spurious decrements.

// File: rtl/xtcal_pkg.sv
package xtcal_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_GAP  = 2'd1,
    S_REQ  = 2'd2,
    S_FIN  = 2'd3
  } cal_state_e;
endpackage

// File: rtl/xtcal_judge.sv
module xtcal_judge #(
  parameter int RES_W = 8
) (
  input  logic [RES_W-1:0] result,
  input  logic [RES_W-1:0] target,
  input  logic             neg_dir,
  output logic             above,
  output logic             keep
);
  // Positive direction keeps a bit while the result stays above target;
  // negative direction keeps it while the result has not yet crossed it.
  always_comb begin
    above = (result > target);
    keep  = neg_dir ? !above : above;
  end
endmodule

// File: rtl/xtcal_seq.sv
module xtcal_seq
  import xtcal_pkg::*;
#(
  parameter int MAG_W = 8,
  parameter int RES_W = 8,
  parameter int TGT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             elec_only,
  input  logic [TGT_W-1:0] target_code,
  input  logic             irq_clr,
  input  logic             meas_done,
  input  logic             above,
  input  logic             keep,
  output logic             meas_req,
  output logic [MAG_W-1:0] trial_mag,
  output logic             trial_sign,
  output logic             pd_connect,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic             load,
  output logic [RES_W-1:0] target
);
  localparam int STEP_W = $clog2(MAG_W + 1);
  localparam logic [STEP_W-1:0] LAST    = STEP_W'(MAG_W);
  localparam logic [MAG_W-1:0]  TOP_BIT = {1'b1, {(MAG_W-1){1'b0}}};
  localparam logic [MAG_W-1:0]  ALL_ONE = '1;

  cal_state_e        state;
  logic [STEP_W-1:0] step;
  logic              elec_q;
  logic [MAG_W-1:0]  cur_mask, kept, final_mag;
  logic [RES_W-1:0]  tgt_dec;
  logic              start_ok;

  always_comb begin
    tgt_dec   = (RES_W'(1) << target_code) - RES_W'(1);
    cur_mask  = TOP_BIT >> (step - STEP_W'(1));
    kept      = keep ? trial_mag : (trial_mag & ~cur_mask);
    final_mag = (trial_sign && kept != ALL_ONE) ? kept + MAG_W'(1) : kept;
    start_ok  = start && (state == S_IDLE);
    load      = (state == S_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_GAP;      // automatic electrical-only run after reset
      step       <= '0;
      trial_mag  <= '0;
      trial_sign <= 1'b0;
      elec_q     <= 1'b1;
      pd_connect <= 1'b0;
      busy       <= 1'b1;
      done       <= 1'b0;
      irq        <= 1'b0;
      meas_req   <= 1'b0;
      target     <= tgt_dec;
    end else begin
      if (state == S_FIN)  irq <= 1'b1;
      else if (irq_clr)    irq <= 1'b0;
      unique case (state)
        S_IDLE: if (start_ok) begin
          state      <= S_GAP;
          step       <= '0;
          trial_mag  <= '0;
          trial_sign <= 1'b0;
          elec_q     <= elec_only;
          pd_connect <= !elec_only;
          busy       <= 1'b1;
          done       <= 1'b0;
          target     <= tgt_dec;
        end
        S_GAP: begin
          meas_req <= 1'b1;
          state    <= S_REQ;
        end
        S_REQ: if (meas_done) begin
          meas_req <= 1'b0;
          if (step == '0) begin
            trial_sign <= !above;
            trial_mag  <= TOP_BIT;
            step       <= step + STEP_W'(1);
            state      <= S_GAP;
          end else if (step == LAST) begin
            trial_mag  <= final_mag;
            state      <= S_FIN;
          end else begin
            trial_mag  <= kept | (cur_mask >> 1);
            step       <= step + STEP_W'(1);
            state      <= S_GAP;
          end
        end
        S_FIN: begin
          busy       <= 1'b0;
          done       <= 1'b1;
          pd_connect <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    meas_req |-> busy); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (meas_req && !meas_done) |=> meas_req); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (meas_req && meas_done) |=> !meas_req); // R5
  AST_STEP_MAX: assert property (@(posedge clk) disable iff (rst)
    step <= LAST); // R5
  AST_PD_ELEC: assert property (@(posedge clk) disable iff (rst)
    (busy && elec_q) |-> !pd_connect); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == S_REQ && start && !meas_done) |=> ($stable(step) && $stable(target))); // R10
endmodule

// File: rtl/xtcal_store.sv
module xtcal_store #(
  parameter int MAG_W = 8,
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [MAG_W-1:0] load_mag,
  input  logic             load_sign,
  input  logic             block,
  input  logic             adj_en,
  input  logic             run_valid,
  input  logic [RES_W-1:0] run_result,
  output logic [MAG_W-1:0] off_mag,
  output logic             off_sign
);
  logic dec_hit;

  always_comb dec_hit = !block && adj_en && run_valid &&
                        (run_result == '0) && (off_mag != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_mag  <= '0;
      off_sign <= 1'b0;
    end else if (load) begin
      off_mag  <= load_mag;
      off_sign <= load_sign;
    end else if (dec_hit) begin
      off_mag  <= off_mag - MAG_W'(1);
    end
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (block && !load) |=> ($stable(off_mag) && $stable(off_sign))); // R7
  AST_DEC_LOWERS: assert property (@(posedge clk) disable iff (rst)
    (!load && !block && adj_en && run_valid && run_result == '0 && off_mag != '0)
      |=> (off_mag < $past(off_mag))); // R8
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!load && off_mag == '0) |=> (off_mag == '0)); // R8
  AST_SIGN_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(off_sign)); // R8
endmodule

// File: rtl/xtcal_top.sv
module xtcal_top #(
  parameter int MAG_W = 8,
  parameter int RES_W = 8,
  parameter int TGT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_start,
  input  logic             elec_only,
  input  logic [TGT_W-1:0] target_code,
  input  logic             irq_clr,
  input  logic             auto_adj_en,
  output logic             meas_req,
  output logic [MAG_W-1:0] trial_mag,
  output logic             trial_sign,
  output logic             pd_connect,
  input  logic             meas_done,
  input  logic [RES_W-1:0] meas_result,
  input  logic             run_valid,
  input  logic [RES_W-1:0] run_result,
  output logic [MAG_W-1:0] offset_mag,
  output logic             offset_sign,
  output logic             cal_busy,
  output logic             cal_done,
  output logic             cal_irq
);
  logic             above, keep, load;
  logic [RES_W-1:0] target;

  xtcal_judge #(.RES_W(RES_W)) u_judge (
    .result  (meas_result),
    .target  (target),
    .neg_dir (trial_sign),
    .above   (above),
    .keep    (keep)
  );

  xtcal_seq #(.MAG_W(MAG_W), .RES_W(RES_W), .TGT_W(TGT_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (cal_start),
    .elec_only   (elec_only),
    .target_code (target_code),
    .irq_clr     (irq_clr),
    .meas_done   (meas_done),
    .above       (above),
    .keep        (keep),
    .meas_req    (meas_req),
    .trial_mag   (trial_mag),
    .trial_sign  (trial_sign),
    .pd_connect  (pd_connect),
    .busy        (cal_busy),
    .done        (cal_done),
    .irq         (cal_irq),
    .load        (load),
    .target      (target)
  );

  xtcal_store #(.MAG_W(MAG_W), .RES_W(RES_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_mag   (trial_mag),
    .load_sign  (trial_sign),
    .block      (cal_busy),
    .adj_en     (auto_adj_en),
    .run_valid  (run_valid),
    .run_result (run_result),
    .off_mag    (offset_mag),
    .off_sign   (offset_sign)
  );
endmodule

// File: tb/test_xtcal_top.sv
module test_xtcal_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cal_start = 1'b0, elec_only = 1'b0, irq_clr = 1'b0, auto_adj_en = 1'b0;
  logic [2:0] target_code = 3'd3;
  logic       meas_req, trial_sign, pd_connect, offset_sign, cal_busy, cal_done, cal_irq;
  logic [7:0] trial_mag, offset_mag;
  logic       meas_done = 1'b0, run_valid = 1'b0;
  logic [7:0] meas_result = '0, run_result = '0;

  int tests = 0, fails = 0, cycles = 0;
  int base = 40;
  int req_cnt = 0, pd_hi = 0, pd_lo = 0;
  logic [8:0] exp_q[$];
  logic done_prev = 1'b0;

  always #5 clk = ~clk;

  xtcal_top i_xtcal_top (
    .clk(clk), .rst(rst), .cal_start(cal_start), .elec_only(elec_only),
    .target_code(target_code), .irq_clr(irq_clr), .auto_adj_en(auto_adj_en),
    .meas_req(meas_req), .trial_mag(trial_mag), .trial_sign(trial_sign),
    .pd_connect(pd_connect), .meas_done(meas_done), .meas_result(meas_result),
    .run_valid(run_valid), .run_result(run_result), .offset_mag(offset_mag),
    .offset_sign(offset_sign), .cal_busy(cal_busy), .cal_done(cal_done), .cal_irq(cal_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected {sign, mag} from the requirements: result = clamp(base - offset)
  function automatic logic [8:0] exp_off(input int b, input int code);
    int t = (1 << code) - 1;
    int m;
    if (b > t) return {1'b0, 8'(b - t - 1)};
    m = t + 1 - b;
    if (m > 255) m = 255;
    return {1'b1, 8'(m)};
  endfunction

  // Analog front-end responder
  initial forever begin
    @(negedge clk);
    if (!rst && meas_req) begin
      int v;
      req_cnt++;
      if (pd_connect) pd_hi++; else pd_lo++;
      repeat (2) @(negedge clk);
      v = trial_sign ? base + int'(trial_mag) : base - int'(trial_mag);
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      meas_result = 8'(v);
      meas_done = 1'b1;
      @(negedge clk);
      meas_done = 1'b0;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && cal_done && !done_prev) begin
      logic [8:0] e;
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected completion", 1, 0);
      else begin
        e = exp_q.pop_front();
        check({offset_sign, offset_mag} == e, "R1 R2 R3 R4 offset", int'({offset_sign, offset_mag}), int'(e));
        check(cal_irq == 1'b1 && cal_busy == 1'b0, "R7 flags at completion", int'(cal_irq), 1);
      end
    end
    done_prev = cal_done;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        check(1'b0, "watchdog", cycles, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!cal_done && n < 5000) begin @(negedge clk); n++; end
    check(cal_done == 1'b1, "R7 run completes", int'(cal_done), 1);
  endtask

  task automatic post_run(input bit elec);
    check(req_cnt == 9, "R5 measurement count", req_cnt, 9);
    if (elec) check(pd_hi == 0, "R6 pd_connect low in electrical run", pd_hi, 0);
    else      check(pd_lo == 0, "R6 pd_connect high in normal run", pd_lo, 0);
    check(meas_req == 1'b0, "R5 request idle after run", int'(meas_req), 0);
  endtask

  task automatic run_cal(input int b, input int code, input bit elec, input bit poke);
    base = b; target_code = 3'(code); elec_only = elec;
    req_cnt = 0; pd_hi = 0; pd_lo = 0;
    exp_q.push_back(exp_off(b, code));
    @(negedge clk) cal_start = 1'b1;
    @(negedge clk) cal_start = 1'b0;
    check(cal_done == 1'b0 && cal_busy == 1'b1, "R7 start clears done", int'(cal_done), 0);
    if (poke) begin
      repeat (12) @(negedge clk);
      target_code = 3'd0; elec_only = !elec; cal_start = 1'b1;
      @(negedge clk) cal_start = 1'b0;
      target_code = 3'(code); elec_only = elec;
    end
    wait_done();
    post_run(elec);
  endtask

  initial begin
    base = 40; target_code = 3'd3;
    repeat (3) @(negedge clk);
    check(offset_mag == 8'd0 && offset_sign == 1'b0, "R9 offset reset", int'(offset_mag), 0);
    check(cal_done == 1'b0 && cal_irq == 1'b0, "R9 flags reset", int'(cal_done), 0);
    check(meas_req == 1'b0, "R9 no request in reset", int'(meas_req), 0);
    exp_q.push_back(exp_off(40, 3));
    rst = 1'b0;
    @(negedge clk);
    wait_done();
    post_run(1'b1);                       // R9 automatic electrical-only run

    run_cal(200, 7, 1'b0, 1'b1);          // R10 start poked mid-run
    run_cal(10, 5, 1'b0, 1'b0);
    run_cal(0, 0, 1'b1, 1'b0);
    run_cal(63, 6, 1'b0, 1'b0);           // base equals target
    run_cal(255, 0, 1'b0, 1'b0);          // +254

    // R8 auto-adjust
    @(negedge clk) auto_adj_en = 1'b1; run_valid = 1'b1; run_result = 8'd0;
    @(negedge clk) run_valid = 1'b0;
    check(offset_mag == 8'd253, "R8 decrement on zero", int'(offset_mag), 253);
    run_valid = 1'b1; run_result = 8'd9;
    @(negedge clk) run_valid = 1'b0;
    check(offset_mag == 8'd253, "R8 nonzero result ignored", int'(offset_mag), 253);
    auto_adj_en = 1'b0; run_valid = 1'b1; run_result = 8'd0;
    @(negedge clk) run_valid = 1'b0;
    check(offset_mag == 8'd253 && offset_sign == 1'b0, "R8 disabled ignored", int'(offset_mag), 253);

    // R7 interrupt clear
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    check(cal_irq == 1'b0, "R7 irq cleared", int'(cal_irq), 0);
    check(cal_done == 1'b1, "R7 done kept after irq clear", int'(cal_done), 1);

    run_cal(1, 0, 1'b0, 1'b0);            // all bits discarded, +0
    @(negedge clk) auto_adj_en = 1'b1; run_valid = 1'b1; run_result = 8'd0;
    @(negedge clk) run_valid = 1'b0;
    check(offset_mag == 8'd0 && offset_sign == 1'b0, "R8 no wrap at zero", int'(offset_mag), 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 every run reported", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule